// File: doc/BRIEF.md
# Transmit CAS Signaling Inserter

This block supplies the per-channel signaling nibble (A, B, C, D) that a T1 or E1 transmit framer places into its outgoing stream. Each channel gets its bits from one of two sources. The first is a bank of sixteen CPU-written signaling registers, each holding the nibbles of two channels. The second is a serial hardware signaling stream. The source is picked per channel by enable bits. A few mode bits decide whether those enables count in T1 mode, and whether they are overridden in E1 mode.

On every multiframe boundary, marked by a one-cycle `mf_start` pulse, both sources are captured together into a 32-nibble holding stage. The framer then reads that stage by slot number for the whole multiframe, so CPU writes made during a multiframe cannot corrupt it. The same boundary sets a latched flag. The CPU reads this flag to learn when it may load the next multiframe's values, and the flag can also raise an interrupt.

The framer addresses the output by slot number: T1 channel index 0..23, or E1 timeslot 0..31. In E1 the block maps timeslots to the 30 voice-channel nibbles and skips the framing and signaling timeslots. In T1 superframe (D4) operation only the A and B bits are presented.

Top module: `casx_tx_sig_inserter`

## Requirements
- R1: After reset, every signaling register, enable register, the control register and the multiframe flag read 0, `mf_irq` is 0, and the holding stage is all zero, so `sig_out` is 0 for every slot.
- R2: CPU register map (writes take effect on the clock edge while `cpu_we`=1; `cpu_rdata` is combinational from `cpu_addr`):
  - addresses 0..15 are the signaling registers;
  - addresses 16..19 are the enable registers, where bit b of address 16+j enables channel 8j+b;
  - address 20 is control, with bit0 E1 mode, bit1 extended-superframe (ESF) mode, bit2 T1 software enable, bit3 E1 force-all-registers and bit4 interrupt enable;
  - address 21 is status, with bit0 the multiframe flag.
- R3: The holding stage changes only on a clock edge where `mf_start`=1; register or hardware-input changes between boundaries leave `sig_out` unchanged until the next boundary.
- R4: The multiframe flag is set on every boundary and stays set until status is written with bit0=1. A boundary in the same cycle as the clear leaves it set. `mf_irq` = flag AND interrupt enable.
- R5: In T1 mode (control bit0=0), channel n takes its nibble from the registers only if the software enable and enable bit n are both 1; otherwise it takes it from the hardware stream.
- R6: In E1 mode, force-all=1 sources every channel from the registers; with force-all=0 the per-channel enable bit alone picks the register source.
- R7: Signaling register k holds channel 2k in bits 7:4 and channel 2k+1 in bits 3:0, with A in the most significant bit of each nibble; `sig_out[3:0]` is {A,B,C,D}.
- R8: In T1 with ESF=0 (D4), `sig_out[1:0]` (C, D) is 0, using the current control value; with ESF=1, and always in E1, all four bits are presented.
- R9: In E1, timeslots 1..15 present channels 0..14 and timeslots 17..31 present channels 15..29. Timeslots 0 and 16 give `sig_valid`=0 and `sig_out`=0.
- R10: The hardware stream shifts one bit per cycle with `hw_sig_valid`=1. Bits shifted in before the boundary cycle are used. The most recent 128 bits are read oldest first as channel 0 A, B, C, D, then channel 1, and so on.
- R11: In T1, slots 0..23 present channels 0..23 with `sig_valid`=1; slots 24..31 give `sig_valid`=0 and `sig_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 5 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` |
| mf_start | input | 1 | Multiframe boundary pulse |
| hw_sig_in | input | 1 | Serial hardware signaling bit |
| hw_sig_valid | input | 1 | Shift enable for `hw_sig_in` |
| slot_sel | input | 5 | Slot requested by the framer |
| sig_out | output | 4 | Signaling nibble {A,B,C,D} for `slot_sel` |
| sig_valid | output | 1 | Slot carries channel signaling |
| mf_irq | output | 1 | Multiframe interrupt |

## Verification
The assertions check these rules on every cycle:
- the holding stage keeps its value between boundaries;
- the flag rises after each boundary and falls after a clear that has no boundary in the same cycle;
- each shifted bit lands at the bottom of the hardware shift stage;
- C and D are zero in D4 mode;
- E1 timeslots 0 and 16 are never valid.

Only the bench scenarios can show the rest:
- which source each channel takes under each mode combination;
- the nibble order within a register;
- the timeslot-to-channel mapping;
- the bit order of the serial stream;
- that a mid-multiframe write appears only after the next boundary.

// File: rtl/casx_pkg.sv
`timescale 1ns/1ps
package casx_pkg;
  localparam int DW       = 8;   // CPU data width
  localparam int AW       = 5;   // CPU address width
  localparam int NIB      = 4;   // signaling bits per channel
  localparam int CTRLW    = 5;   // control register width
  localparam int CB_E1    = 0;
  localparam int CB_ESF   = 1;
  localparam int CB_SWEN  = 2;
  localparam int CB_T16   = 3;
  localparam int CB_IRQ   = 4;
  localparam int T1_SLOTS = 24;
  localparam int E1_SIG_TS = 16;
endpackage

// File: rtl/casx_regfile.sv
`timescale 1ns/1ps
module casx_regfile
  import casx_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_we,
  input  logic [AW-1:0]           cpu_addr,
  input  logic [DW-1:0]           cpu_wdata,
  output logic [DW-1:0]           cpu_rdata,
  input  logic                    mf_start,
  output logic [2*NREG*NIB-1:0]   reg_nib,
  output logic [2*NREG-1:0]       en_flat,
  output logic [CTRLW-1:0]        ctrl,
  output logic                    mf_flag
);
  localparam int NCH       = 2 * NREG;
  localparam int NEN       = NCH / DW;
  localparam int ADDR_CTRL = NREG + NEN;
  localparam int ADDR_STS  = NREG + NEN + 1;

  logic [NREG-1:0][DW-1:0] sreg_q, sreg_d;
  logic [NEN-1:0][DW-1:0]  en_q, en_d;
  logic [CTRLW-1:0]        ctrl_q, ctrl_d;
  logic                    flag_q, flag_d;
  logic                    sts_clr;

  assign sts_clr = cpu_we && (cpu_addr == AW'(ADDR_STS)) && cpu_wdata[0];

  // next state
  always_comb begin
    sreg_d = sreg_q;
    en_d   = en_q;
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    for (int k = 0; k < NREG; k++) begin
      if (cpu_we && (cpu_addr == AW'(k))) sreg_d[k] = cpu_wdata;
    end
    for (int j = 0; j < NEN; j++) begin
      if (cpu_we && (cpu_addr == AW'(NREG + j))) en_d[j] = cpu_wdata;
    end
    if (cpu_we && (cpu_addr == AW'(ADDR_CTRL))) ctrl_d = cpu_wdata[CTRLW-1:0];
    if (sts_clr)  flag_d = 1'b0;
    if (mf_start) flag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      en_q   <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      en_q   <= en_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  // read mux
  always_comb begin
    cpu_rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      if (cpu_addr == AW'(k)) cpu_rdata = sreg_q[k];
    end
    for (int j = 0; j < NEN; j++) begin
      if (cpu_addr == AW'(NREG + j)) cpu_rdata = en_q[j];
    end
    if (cpu_addr == AW'(ADDR_CTRL)) cpu_rdata = {{(DW-CTRLW){1'b0}}, ctrl_q};
    if (cpu_addr == AW'(ADDR_STS))  cpu_rdata = {{(DW-1){1'b0}}, flag_q};
  end

  // channel-indexed views: even channel in the upper nibble
  for (genvar k = 0; k < NREG; k++) begin : g_nib
    assign reg_nib[(2*k)*NIB   +: NIB] = sreg_q[k][DW-1 -: NIB];
    assign reg_nib[(2*k+1)*NIB +: NIB] = sreg_q[k][NIB-1:0];
  end
  for (genvar n = 0; n < NCH; n++) begin : g_en
    assign en_flat[n] = en_q[n / DW][n % DW];
  end

  assign ctrl    = ctrl_q;
  assign mf_flag = flag_q;

  p_flag_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> mf_flag);
  p_flag_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !mf_start) |=> !mf_flag);
endmodule

// File: rtl/casx_hwshift.sv
`timescale 1ns/1ps
module casx_hwshift
  import casx_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_sig_in,
  input  logic               hw_sig_valid,
  output logic [NCH*NIB-1:0] hw_nib
);
  localparam int W = NCH * NIB;

  logic [W-1:0] shift_q, shift_d;

  always_comb begin
    shift_d = shift_q;
    if (hw_sig_valid) shift_d = {shift_q[W-2:0], hw_sig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  // oldest bits (top of the shift stage) belong to channel 0
  for (genvar n = 0; n < NCH; n++) begin : g_map
    assign hw_nib[n*NIB +: NIB] = shift_q[(NCH-1-n)*NIB +: NIB];
  end

  p_shift_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_sig_valid |=> (shift_q[0] == $past(hw_sig_in)));
endmodule

// File: rtl/casx_snapshot.sv
`timescale 1ns/1ps
module casx_snapshot
  import casx_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mf_start,
  input  logic [NCH*NIB-1:0] reg_nib,
  input  logic [NCH*NIB-1:0] hw_nib,
  input  logic [NCH-1:0]     en_flat,
  input  logic               e1_mode,
  input  logic               sw_en,
  input  logic               force_all,
  output logic [NCH*NIB-1:0] snap
);
  logic [NCH*NIB-1:0] pick, snap_q, snap_d;
  logic [NCH-1:0]     use_reg;

  for (genvar n = 0; n < NCH; n++) begin : g_sel
    assign use_reg[n] = e1_mode ? (force_all | en_flat[n]) : (sw_en & en_flat[n]);
    assign pick[n*NIB +: NIB] = use_reg[n] ? reg_nib[n*NIB +: NIB]
                                           : hw_nib[n*NIB +: NIB];
  end

  always_comb begin
    snap_d = snap_q;
    if (mf_start) snap_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign snap = snap_q;

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_start |=> $stable(snap_q));
endmodule

// File: rtl/casx_chanmap.sv
`timescale 1ns/1ps
module casx_chanmap
  import casx_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                   e1_mode,
  input  logic                   esf_mode,
  input  logic [$clog2(NCH)-1:0] slot_sel,
  input  logic [NCH*NIB-1:0]     snap,
  output logic [NIB-1:0]         sig_out,
  output logic                   sig_valid
);
  localparam int SW = $clog2(NCH);

  logic [SW-1:0]  idx;
  logic [NIB-1:0] raw;
  logic           vld;

  always_comb begin
    if (e1_mode) begin
      vld = (slot_sel != '0) && (slot_sel != SW'(E1_SIG_TS));
      idx = (slot_sel < SW'(E1_SIG_TS)) ? slot_sel - SW'(1) : slot_sel - SW'(2);
    end else begin
      vld = (slot_sel < SW'(T1_SLOTS));
      idx = slot_sel;
    end
    raw = snap[idx*NIB +: NIB];
    if (!vld) begin
      sig_out = '0;
    end else if (!e1_mode && !esf_mode) begin
      sig_out = {raw[NIB-1 -: 2], 2'b00};
    end else begin
      sig_out = raw;
    end
    sig_valid = vld;
  end
endmodule

// File: rtl/casx_tx_sig_inserter.sv
`timescale 1ns/1ps
module casx_tx_sig_inserter
  import casx_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_we,
  input  logic [AW-1:0]                 cpu_addr,
  input  logic [DW-1:0]                 cpu_wdata,
  output logic [DW-1:0]                 cpu_rdata,
  input  logic                          mf_start,
  input  logic                          hw_sig_in,
  input  logic                          hw_sig_valid,
  input  logic [$clog2(2*NREG)-1:0]     slot_sel,
  output logic [NIB-1:0]                sig_out,
  output logic                          sig_valid,
  output logic                          mf_irq
);
  localparam int NCH = 2 * NREG;

  logic                rst_s1, rst_s2;
  logic [NCH*NIB-1:0]  reg_nib, hw_nib, snap;
  logic [NCH-1:0]      en_flat;
  logic [CTRLW-1:0]    ctrl;
  logic                mf_flag;
  logic                e1_mode, esf_mode;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  casx_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_s2), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mf_start(mf_start),
    .reg_nib(reg_nib), .en_flat(en_flat), .ctrl(ctrl), .mf_flag(mf_flag)
  );

  casx_hwshift #(.NCH(NCH)) u_hw (
    .clk(clk), .rst_n(rst_s2), .hw_sig_in(hw_sig_in),
    .hw_sig_valid(hw_sig_valid), .hw_nib(hw_nib)
  );

  assign e1_mode  = ctrl[CB_E1];
  assign esf_mode = ctrl[CB_ESF];

  casx_snapshot #(.NCH(NCH)) u_snap (
    .clk(clk), .rst_n(rst_s2), .mf_start(mf_start), .reg_nib(reg_nib),
    .hw_nib(hw_nib), .en_flat(en_flat), .e1_mode(e1_mode),
    .sw_en(ctrl[CB_SWEN]), .force_all(ctrl[CB_T16]), .snap(snap)
  );

  casx_chanmap #(.NCH(NCH)) u_map (
    .e1_mode(e1_mode), .esf_mode(esf_mode), .slot_sel(slot_sel),
    .snap(snap), .sig_out(sig_out), .sig_valid(sig_valid)
  );

  assign mf_irq = mf_flag & ctrl[CB_IRQ];

  p_d4_cd_zero_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    (!e1_mode && !esf_mode) |-> (sig_out[1:0] == 2'b00));
  p_e1_no_cas_slot_r9: assert property (@(posedge clk) disable iff (!rst_s2)
    (e1_mode && (slot_sel == '0 || slot_sel == 5'd16)) |-> (!sig_valid && sig_out == '0));
endmodule

// File: tb/test_casx_tx_sig_inserter.sv
`timescale 1ns/1ps
module test_casx_tx_sig_inserter;
  localparam real CLK_NS = 4.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       mf_start = 1'b0;
  logic       hw_sig_in = 1'b0;
  logic       hw_sig_valid = 1'b0;
  logic [4:0] slot_sel = '0;
  logic [3:0] sig_out;
  logic       sig_valid;
  logic       mf_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  casx_tx_sig_inserter i_casx_tx_sig_inserter (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mf_start(mf_start),
    .hw_sig_in(hw_sig_in), .hw_sig_valid(hw_sig_valid), .slot_sel(slot_sel),
    .sig_out(sig_out), .sig_valid(sig_valid), .mf_irq(mf_irq)
  );

  // {slot, expected nibble, expected valid} for T1 ESF, software enable on,
  // channels 0, 2, 23 on registers, others from the hardware stream
  localparam logic [9:0] VEC [9] = '{
    {5'd0,  4'hA, 1'b1},   // R7 reg0 upper
    {5'd1,  4'h4, 1'b1},   // R5/R10 hw(1)
    {5'd2,  4'h6, 1'b1},   // R7 reg1 upper
    {5'd3,  4'h6, 1'b1},   // R10 hw(3)
    {5'd5,  4'h0, 1'b1},   // R10 hw(5)
    {5'd22, 4'h3, 1'b1},   // R10 hw(22)
    {5'd23, 4'hE, 1'b1},   // R7 reg11 lower
    {5'd24, 4'h0, 1'b0},   // R11
    {5'd31, 4'h0, 1'b0}    // R11
  };

  function automatic logic [3:0] hwn(int n);
    return 4'(n) ^ 4'h5;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk(req, cpu_rdata, exp);
  endtask

  task automatic mf_pulse();
    @(negedge clk);
    mf_start = 1'b1;
    @(negedge clk);
    mf_start = 1'b0;
  endtask

  task automatic slot_chk(string req, logic [4:0] s, logic [3:0] eo, logic ev);
    @(negedge clk);
    slot_sel = s;
    #1;
    chk(req, {4'h0, sig_out}, {4'h0, eo});
    chk(req, {7'h0, sig_valid}, {7'h0, ev});
  endtask

  task automatic hw_stream();
    for (int n = 0; n < 32; n++) begin
      for (int b = 3; b >= 0; b--) begin
        @(negedge clk);
        hw_sig_valid = 1'b1;
        hw_sig_in = hwn(n)[b];
      end
    end
    @(negedge clk);
    hw_sig_valid = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 ctrl", 5'd20, 8'h00);
    rd_chk("R1 status", 5'd21, 8'h00);
    rd_chk("R1 reg0", 5'd0, 8'h00);
    rd_chk("R1 en0", 5'd16, 8'h00);
    chk("R1 irq", {7'h0, mf_irq}, 8'h00);
    slot_chk("R1 slot0", 5'd0, 4'h0, 1'b1);

    // configuration, R2 readback
    wr(5'd0, 8'hA3);
    wr(5'd1, 8'h6C);
    wr(5'd11, 8'h9E);
    wr(5'd7, 8'h3C);
    wr(5'd14, 8'h0B);
    wr(5'd5, 8'h5A);
    wr(5'd16, 8'h05);
    wr(5'd18, 8'h80);
    wr(5'd20, 8'h06);
    rd_chk("R2 reg5", 5'd5, 8'h5A);
    rd_chk("R2 en2", 5'd18, 8'h80);
    rd_chk("R2 ctrl", 5'd20, 8'h06);
    slot_chk("R3 before boundary", 5'd0, 4'h0, 1'b1);

    hw_stream();
    mf_pulse();

    // table walk: R5 R7 R10 R11
    foreach (VEC[i]) begin
      slot_chk("R5/R7/R10/R11 table", VEC[i][9:5], VEC[i][4:1], VEC[i][0]);
    end

    // R4 flag and interrupt
    rd_chk("R4 flag set", 5'd21, 8'h01);
    chk("R4 irq masked", {7'h0, mf_irq}, 8'h00);
    wr(5'd20, 8'h16);
    #1 chk("R4 irq enabled", {7'h0, mf_irq}, 8'h01);
    wr(5'd21, 8'h01);
    rd_chk("R4 flag cleared", 5'd21, 8'h00);
    chk("R4 irq after clear", {7'h0, mf_irq}, 8'h00);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 5'd21; cpu_wdata = 8'h01; mf_start = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; mf_start = 1'b0;
    rd_chk("R4 set wins over clear", 5'd21, 8'h01);
    wr(5'd21, 8'h01);

    // R3 mid-multiframe write held until boundary
    wr(5'd0, 8'h11);
    slot_chk("R3 old value kept", 5'd0, 4'hA, 1'b1);
    mf_pulse();
    slot_chk("R3 new value after boundary", 5'd0, 4'h1, 1'b1);

    // R8 D4 masks C and D
    wr(5'd20, 8'h04);
    slot_chk("R8 d4 slot2", 5'd2, 4'h4, 1'b1);
    slot_chk("R8 d4 slot0", 5'd0, 4'h0, 1'b1);

    // R5 global software enable off: all hardware
    wr(5'd20, 8'h02);
    mf_pulse();
    slot_chk("R5 sw off slot0", 5'd0, hwn(0), 1'b1);
    slot_chk("R5 sw off slot23", 5'd23, hwn(23), 1'b1);

    // R6 R9 E1 with per-channel enables
    wr(5'd20, 8'h01);
    mf_pulse();
    slot_chk("R9 ts0", 5'd0, 4'h0, 1'b0);
    slot_chk("R9 ts16", 5'd16, 4'h0, 1'b0);
    slot_chk("R6 ts1 reg", 5'd1, 4'h1, 1'b1);
    slot_chk("R6 ts2 hw", 5'd2, hwn(1), 1'b1);
    slot_chk("R6 ts3 reg", 5'd3, 4'h6, 1'b1);
    slot_chk("R9 ts17 hw", 5'd17, hwn(15), 1'b1);
    slot_chk("R9 ts24 hw", 5'd24, hwn(22), 1'b1);

    // R6 force-all in E1
    wr(5'd20, 8'h09);
    mf_pulse();
    slot_chk("R6 force ts17", 5'd17, 4'hC, 1'b1);
    slot_chk("R6 force ts2", 5'd2, 4'h1, 1'b1);
    slot_chk("R9 force ts31", 5'd31, 4'hB, 1'b1);
    slot_chk("R9 force ts15", 5'd15, 4'h3, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule